// File: doc/BRIEF.md
# Two-Wire Bus Stuck-Line Recovery

This block runs once per request, normally right after power-up, to find out whether an open-drain two-wire bus (I2C style) is usable. A target device can be left holding the data line low when a transfer was cut off partway through. The block releases both lines, waits one delay period, and then sorts the bus into one of three cases. In the first case both lines are high and the bus is free. In the second the clock line is low, which the block cannot fix. In the third the clock is high but data is held low, and the block works to free it.

In the third case the block clocks the bus slowly by pulling SCL low and then letting it go. After each released phase it checks whether the target has let go of SDA. It stops at the first sample that shows SDA high. The number of clocks is limited to cover a worst-case partial byte plus its acknowledge from the target. The block only ever pulls a line low or releases it; the pull-ups make the high level. Each request produces one result: a single-cycle `done` strobe and a `bus_clear` flag that stays valid until the next request.

Top module: `i2c_bus_unstick`

## Requirements
- R1: After reset, `done_o`, `bus_clear_o` and `scl_low_o` are 0, so both lines are released.
- R2: When `start_i` is taken, both lines are released for `HALF_CYCLES` clock cycles before any decision. If both synchronized lines are then high, `done_o` rises `HALF_CYCLES` cycles after the start edge, `bus_clear_o` is 1 and no clock pulse is produced.
- R3: If SCL reads low at the first decision, the result is stuck (`bus_clear_o` = 0) at that same decision point, and no pulse is produced.
- R4: If SCL reads high and SDA reads low, recovery pulses follow. Each pulse holds `scl_low_o` = 1 for exactly `HALF_CYCLES` cycles and then releases SCL for `HALF_CYCLES` cycles.
- R5: SDA is sampled at the end of every released phase. If it is high, the result is clear right away, so with p pulses `done_o` rises `HALF_CYCLES*(1+2p)` cycles after the start edge.
- R6: No more than `MAX_PULSES` (default 18) pulses are produced. If SDA is still low after the last released phase, the result is stuck.
- R7: `done_o` is high for exactly one cycle per request. `bus_clear_o` goes to 0 when a request is taken and keeps its result value after `done_o` until the next request is taken.
- R8: A `start_i` pulse that arrives during a check has no effect. The running check finishes with its normal timing, and no second `done_o` follows it.
- R9: `sda_low_o` is never asserted, so the block never pulls SDA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a bus check (taken only when idle) |
| done_o | output | 1 | One-cycle strobe when the result is ready |
| bus_clear_o | output | 1 | 1 = bus free, 0 = stuck; valid from `done_o` until next request |
| scl_low_o | output | 1 | Drive-low enable for the clock pin |
| scl_i | input | 1 | Sampled clock pin level (asynchronous) |
| sda_low_o | output | 1 | Drive-low enable for the data pin |
| sda_i | input | 1 | Sampled data pin level (asynchronous) |

## Verification
The hardest case to reach is a target that lets go of SDA on exactly the last allowed pulse, compared with one that needs one more pulse. These two are separated only by the final sample after the eighteenth released phase. To produce them, the bench models a target that holds SDA low until a chosen number of SCL rising edges has passed. The directed cases use 17, 18 and 19 edges, and random cases draw the count on both sides of the limit. A clock line held low from outside and a start request issued in the middle of a check are also forced, to cover the early stuck exit and the ignored request.

// File: rtl/i2c_bus_unstick.sv
module i2c_bus_unstick #(
  parameter int HALF_CYCLES = 8,
  parameter int MAX_PULSES  = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic done_o,
  output logic bus_clear_o,
  output logic scl_low_o,
  input  logic scl_i,
  output logic sda_low_o,
  input  logic sda_i
);
  localparam int CW = $clog2(HALF_CYCLES + 1);
  localparam int PW = $clog2(MAX_PULSES + 1);

  typedef enum logic [1:0] {IDLE, SETTLE, PULSE_LO, PULSE_HI} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [PW-1:0] pulses;
  logic [1:0]    scl_sync, sda_sync;
  logic          scl_s, sda_s, phase_end, busy;

  assign scl_s     = scl_sync[1];
  assign sda_s     = sda_sync[1];
  assign phase_end = (cnt == CW'(HALF_CYCLES - 1));
  assign busy      = (state != IDLE);
  assign sda_low_o = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sync <= 2'b11;
      sda_sync <= 2'b11;
    end else begin
      scl_sync <= {scl_sync[0], scl_i};
      sda_sync <= {sda_sync[0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= IDLE;
      cnt         <= '0;
      pulses      <= '0;
      scl_low_o   <= 1'b0;
      done_o      <= 1'b0;
      bus_clear_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      case (state)
        IDLE: begin
          if (start_i) begin
            state       <= SETTLE;
            cnt         <= '0;
            pulses      <= '0;
            bus_clear_o <= 1'b0;
          end
        end
        SETTLE: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin
            cnt <= '0;
            if (!scl_s) begin
              state       <= IDLE;
              done_o      <= 1'b1;
              bus_clear_o <= 1'b0;
            end else if (sda_s) begin
              state       <= IDLE;
              done_o      <= 1'b1;
              bus_clear_o <= 1'b1;
            end else begin
              state     <= PULSE_LO;
              scl_low_o <= 1'b1;
              pulses    <= PW'(1);
            end
          end
        end
        PULSE_LO: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin
            cnt       <= '0;
            scl_low_o <= 1'b0;
            state     <= PULSE_HI;
          end
        end
        PULSE_HI: begin
          cnt <= cnt + 1'b1;
          if (phase_end) begin
            cnt <= '0;
            if (sda_s) begin
              state       <= IDLE;
              done_o      <= 1'b1;
              bus_clear_o <= 1'b1;
            end else if (pulses == PW'(MAX_PULSES)) begin
              state       <= IDLE;
              done_o      <= 1'b1;
              bus_clear_o <= 1'b0;
            end else begin
              pulses    <= pulses + 1'b1;
              scl_low_o <= 1'b1;
              state     <= PULSE_LO;
            end
          end
        end
        default: state <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_bus_unstick_chk.sv
module i2c_bus_unstick_chk #(
  parameter int HALF_CYCLES = 8,
  parameter int MAX_PULSES  = 18
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy,
  input logic done_o,
  input logic scl_low_o
);
  localparam int RW = $clog2(HALF_CYCLES + 2) + 1;
  localparam int NW = $clog2(MAX_PULSES + 2) + 1;

  logic          prev_low;
  logic [RW-1:0] run;
  logic [NW-1:0] npulse;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_low <= 1'b0;
      run      <= '0;
      npulse   <= '0;
    end else begin
      prev_low <= scl_low_o;
      run      <= scl_low_o ? run + 1'b1 : '0;
      if (start_i && !busy) npulse <= '0;
      else if (scl_low_o && !prev_low) npulse <= npulse + 1'b1;
    end
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  assert_done_released_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !scl_low_o);

  assert_low_phase_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_low && !scl_low_o) |-> (run == RW'(HALF_CYCLES)));

  assert_pulse_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    npulse <= NW'(MAX_PULSES));

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !scl_low_o);
endmodule

bind i2c_bus_unstick i2c_bus_unstick_chk #(
  .HALF_CYCLES(HALF_CYCLES),
  .MAX_PULSES (MAX_PULSES)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start_i  (start_i),
  .busy     (busy),
  .done_o   (done_o),
  .scl_low_o(scl_low_o)
);

// File: tb/tb_i2c_bus_unstick.sv
module tb_i2c_bus_unstick;
  localparam int HALF = 8;
  localparam int MAXP = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic done_o, bus_clear_o, scl_low_o, sda_low_o;
  logic scl_hold = 1'b0;
  logic target_hold = 1'b0;
  int   rel_left = 0;
  logic scl_line, sda_line;

  int checks = 0;
  int errors = 0;

  assign scl_line = !(scl_low_o | scl_hold);
  assign sda_line = !(sda_low_o | target_hold);

  always #10 clk = ~clk;

  i2c_bus_unstick #(.HALF_CYCLES(HALF), .MAX_PULSES(MAXP)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .done_o(done_o),
    .bus_clear_o(bus_clear_o), .scl_low_o(scl_low_o), .scl_i(scl_line),
    .sda_low_o(sda_low_o), .sda_i(sda_line));

  always @(posedge scl_line) begin
    if (target_hold) begin
      if (rel_left <= 1) target_hold = 1'b0;
      else rel_left = rel_left - 1;
    end
  end

  int   pulse_cnt = 0;
  int   run = 0;
  logic prev_low = 1'b0;
  logic low_bad = 1'b0;
  logic sda_seen = 1'b0;
  always @(posedge clk) begin
    if (scl_low_o && !prev_low) pulse_cnt = pulse_cnt + 1;
    if (scl_low_o) run = run + 1;
    else begin
      if (prev_low && run != HALF) low_bad = 1'b1;
      run = 0;
    end
    if (sda_low_o) sda_seen = 1'b1;
    prev_low = scl_low_o;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int k, input bit stuck);
    if (stuck || k == 0) return 0;
    return (k <= MAXP) ? k : MAXP;
  endfunction

  function automatic bit exp_clear(input int k, input bit stuck);
    if (stuck) return 1'b0;
    return k <= MAXP;
  endfunction

  task automatic run_check(input int k, input bit stuck, input bit poke);
    int  n;
    int  p;
    bit  c;
    bit  got;
    p = exp_pulses(k, stuck);
    c = exp_clear(k, stuck);
    @(negedge clk);
    scl_hold = stuck;
    rel_left = k;
    target_hold = (k > 0);
    repeat (4) @(negedge clk);
    pulse_cnt = 0;
    low_bad = 1'b0;
    start_i = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    n = 0;
    got = 1'b0;
    while (n < 2000) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (n == 1) check(bus_clear_o == 1'b0, "R7 flag cleared at start", bus_clear_o, 0);
      start_i = (poke && n == 3);
      if (done_o) begin got = 1'b1; break; end
    end
    start_i = 1'b0;
    check(got, "R2 done seen", got, 1);
    check(n == HALF * (1 + 2 * p), "R5 done latency", n, HALF * (1 + 2 * p));
    check(bus_clear_o == c, stuck ? "R3 stuck scl" : (k > MAXP ? "R6 limit stuck" : "R5 clear"),
          bus_clear_o, c);
    check(pulse_cnt == p, (k > MAXP) ? "R6 pulse count" : "R4 pulse count", pulse_cnt, p);
    check(!low_bad, "R4 low phase length", low_bad, 0);
    @(negedge clk);
    check(done_o == 1'b0, "R7 done one cycle", done_o, 0);
    check(bus_clear_o == c, "R7 flag held", bus_clear_o, c);
    if (poke) begin
      got = 1'b0;
      repeat (3 * HALF) begin
        @(negedge clk);
        if (done_o) got = 1'b1;
      end
      check(!got, "R8 no second done", got, 0);
      check(bus_clear_o == c, "R8 flag unchanged", bus_clear_o, c);
    end
    scl_hold = 1'b0;
    target_hold = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    int seed;
    seed = $urandom(32'h5A17);
    repeat (3) @(negedge clk);
    check(done_o == 1'b0, "R1 done idle", done_o, 0);
    check(bus_clear_o == 1'b0, "R1 flag idle", bus_clear_o, 0);
    check(scl_low_o == 1'b0, "R1 scl released", scl_low_o, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(scl_low_o == 1'b0, "R1 scl released after reset", scl_low_o, 0);

    run_check(0, 1'b0, 1'b0);
    run_check(1, 1'b0, 1'b0);
    run_check(17, 1'b0, 1'b0);
    run_check(18, 1'b0, 1'b0);
    run_check(19, 1'b0, 1'b0);
    run_check(3, 1'b1, 1'b0);
    run_check(0, 1'b1, 1'b0);
    run_check(5, 1'b0, 1'b1);
    run_check(25, 1'b0, 1'b1);
    for (int i = 0; i < 24; i++) begin
      int  k;
      bit  st;
      k  = int'($urandom % 24);
      st = (($urandom % 8) == 0);
      run_check(k, st, ($urandom % 4) == 0);
    end
    check(!sda_seen, "R9 sda never pulled", sda_seen, 0);
    finish_run();
  end
endmodule